// File: doc/BRIEF.md
# XOR-Encoded Two-Write Two-Read Register Memory

This block is a register memory with two write ports and two read ports. Its storage is made only of simple synchronous RAM banks, each with one write port and one read port. The ports are not time-multiplexed onto a faster RAM. Instead, each write port owns a group of banks, and a location's value is the XOR of the matching word across the two groups. A write first reads the other group's word at its address. One cycle later it stores its data XORed with that word into every bank of its own group.

Each group holds three copies: one per external read port, plus a cross copy that the other write port reads. That gives six banks in all. A read XORs the copy from each group that belongs to its port, and the result appears one clock after the address. A registered bypass covers writes that have not yet reached the banks. The parameter `RW_RULE` selects what a read returns when it targets an address written in the same cycle.

Top module: `xmp_regfile`

## Requirements
- R1: All locations read as zero after configuration, before any write.
- R2: Read data for an address presented in cycle t appears on that port's data output in cycle t+1.
- R3: A write with enable high in cycle t is returned by any read presented in cycle t+1 or later, until the address is written again.
- R4: The two read ports work independently, and can return different addresses in the same cycle.
- R5: Two writes to different addresses in the same cycle both take effect.
- R6: When both write ports write the same address in the same cycle, port 1's data is the stored value.
- R7: Writes to one address on consecutive cycles, from either port in any order, leave the most recent data stored.
- R8: With `RW_RULE` = RULE_OLD (encoding 0, the default), a read of an address being written in the same cycle returns the value from before that write.
- R9: With `RW_RULE` = RULE_NEW (encoding 1), a read of an address being written in the same cycle returns the new data. When both ports write that address, it returns port 1's data.
- R10: A write port with its enable low changes no location, whatever its address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of pipeline and bypass state |
| wr0_en_i | input | 1 | Write port 0 enable |
| wr0_addr_i | input | $clog2(DEPTH) | Write port 0 address |
| wr0_data_i | input | WIDTH | Write port 0 data |
| wr1_en_i | input | 1 | Write port 1 enable (wins same-address conflicts) |
| wr1_addr_i | input | $clog2(DEPTH) | Write port 1 address |
| wr1_data_i | input | WIDTH | Write port 1 data |
| rd0_addr_i | input | $clog2(DEPTH) | Read port 0 address |
| rd0_data_o | output | WIDTH | Read port 0 data, one cycle after address |
| rd1_addr_i | input | $clog2(DEPTH) | Read port 1 address |
| rd1_data_o | output | WIDTH | Read port 1 data, one cycle after address |

## Verification
The bench drives two instances, one per `RW_RULE` value, with the same stimulus. Every read result is compared with an array model that records both the value before and the value after each cycle's writes. Directed sequences cover these cases:
- same-address collisions between the write ports;
- alternating back-to-back writes to one address, which separates a working forward path from a stale cross-bank read;
- a read in the same cycle as a write, which separates the two rules;
- writes with enable low but nonzero data.

Random traffic over a narrow address window then makes hazards between the two pipeline stages frequent, on both read ports at once.

// File: rtl/xmp_pkg.sv
package xmp_pkg;
  localparam int unsigned NWR = 2;
  localparam int unsigned NRD = 2;
  localparam int unsigned NCOPY = NRD + 1;  // read-port copies plus one cross copy

  typedef enum logic {
    RULE_OLD = 1'b0,
    RULE_NEW = 1'b1
  } rw_rule_e;
endpackage

// File: rtl/xmp_bank.sv
module xmp_bank #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // read-before-write on a shared edge
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/xmp_wstage.sv
module xmp_wstage #(
  parameter int unsigned AW    = 5,
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] peer_rdata_i,
  input  logic             peer_last_vld_i,
  input  logic [AW-1:0]    peer_last_addr_i,
  input  logic [WIDTH-1:0] peer_last_enc_i,
  output logic             s2_vld_o,
  output logic [AW-1:0]    s2_addr_o,
  output logic [WIDTH-1:0] s2_data_o,
  output logic [WIDTH-1:0] enc_o,
  output logic             last_vld_o,
  output logic [AW-1:0]    last_addr_o,
  output logic [WIDTH-1:0] last_enc_o
);
  logic [WIDTH-1:0] peer_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_o   <= 1'b0;
      last_vld_o <= 1'b0;
    end else begin
      s2_vld_o   <= req_i;
      last_vld_o <= s2_vld_o;
    end
  end

  always_ff @(posedge clk_i) begin
    s2_addr_o   <= addr_i;
    s2_data_o   <= data_i;
    last_addr_o <= s2_addr_o;
    last_enc_o  <= enc_o;
  end

  // peer committed to this address on the edge the cross read was taken
  always_comb begin
    peer_val = peer_rdata_i;
    if (peer_last_vld_i && (peer_last_addr_i == s2_addr_o)) peer_val = peer_last_enc_i;
  end

  assign enc_o = s2_data_o ^ peer_val;

  assert_commit_record_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld_o |=> (last_vld_o && last_addr_o == $past(s2_addr_o) && last_enc_o == $past(enc_o)));
endmodule

// File: rtl/xmp_rport.sv
module xmp_rport
  import xmp_pkg::*;
#(
  parameter int unsigned AW      = 5,
  parameter int unsigned WIDTH   = 32,
  parameter rw_rule_e    RW_RULE = RULE_OLD
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [AW-1:0]            raddr_i,
  input  logic [WIDTH-1:0]         bank0_i,
  input  logic [WIDTH-1:0]         bank1_i,
  input  logic [NWR-1:0]           wr_en_i,
  input  logic [NWR-1:0][AW-1:0]   wr_addr_i,
  input  logic [NWR-1:0][WIDTH-1:0] wr_data_i,
  input  logic [NWR-1:0]           s2_vld_i,
  input  logic [NWR-1:0][AW-1:0]   s2_addr_i,
  input  logic [NWR-1:0][WIDTH-1:0] s2_data_i,
  output logic [WIDTH-1:0]         rdata_o
);
  logic             hit, byp_vld;
  logic [WIDTH-1:0] hit_data, byp_data;

  // later loop iterations take priority: stage 2, then same-cycle port 0, then port 1
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int p = 0; p < NWR; p++) begin
      if (s2_vld_i[p] && s2_addr_i[p] == raddr_i) begin
        hit      = 1'b1;
        hit_data = s2_data_i[p];
      end
    end
    if (RW_RULE == RULE_NEW) begin
      for (int p = 0; p < NWR; p++) begin
        if (wr_en_i[p] && wr_addr_i[p] == raddr_i) begin
          hit      = 1'b1;
          hit_data = wr_data_i[p];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_vld  <= 1'b0;
      byp_data <= '0;
    end else begin
      byp_vld  <= hit;
      byp_data <= hit_data;
    end
  end

  assign rdata_o = byp_vld ? byp_data : (bank0_i ^ bank1_i);

  assert_new_rule_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RW_RULE == RULE_NEW && wr_en_i[1] && wr_addr_i[1] == raddr_i) |=> rdata_o == $past(wr_data_i[1]));

  assert_old_rule_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RW_RULE == RULE_OLD && s2_vld_i[1] && s2_addr_i[1] == raddr_i) |=> rdata_o == $past(s2_data_i[1]));
endmodule

// File: rtl/xmp_regfile.sv
module xmp_regfile
  import xmp_pkg::*;
#(
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned WIDTH   = 32,
  parameter rw_rule_e    RW_RULE = RULE_OLD,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr0_en_i,
  input  logic [AW-1:0]    wr0_addr_i,
  input  logic [WIDTH-1:0] wr0_data_i,
  input  logic             wr1_en_i,
  input  logic [AW-1:0]    wr1_addr_i,
  input  logic [WIDTH-1:0] wr1_data_i,
  input  logic [AW-1:0]    rd0_addr_i,
  output logic [WIDTH-1:0] rd0_data_o,
  input  logic [AW-1:0]    rd1_addr_i,
  output logic [WIDTH-1:0] rd1_data_o
);
  logic [NWR-1:0]            wr_en, req;
  logic [NWR-1:0][AW-1:0]    wr_addr, s2_addr, last_addr;
  logic [NWR-1:0][WIDTH-1:0] wr_data, s2_data, enc, last_enc;
  logic [NWR-1:0]            s2_vld, last_vld;
  logic [NRD-1:0][AW-1:0]    rd_addr;
  logic [WIDTH-1:0]          rd_data [NRD];
  logic [WIDTH-1:0]          bank_q  [NWR][NCOPY];

  assign wr_en   = {wr1_en_i, wr0_en_i};
  assign wr_addr = {wr1_addr_i, wr0_addr_i};
  assign wr_data = {wr1_data_i, wr0_data_i};
  assign rd_addr = {rd1_addr_i, rd0_addr_i};

  // port 1 wins: a colliding port 0 write is dropped
  assign req[0] = wr_en[0] & ~(wr_en[1] & (wr_addr[0] == wr_addr[1]));
  assign req[1] = wr_en[1];

  for (genvar g = 0; g < NWR; g++) begin : g_grp
    localparam int unsigned PEER = NWR - 1 - g;

    xmp_wstage #(.AW(AW), .WIDTH(WIDTH)) u_wstage (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .req_i           (req[g]),
      .addr_i          (wr_addr[g]),
      .data_i          (wr_data[g]),
      .peer_rdata_i    (bank_q[PEER][NCOPY-1]),
      .peer_last_vld_i (last_vld[PEER]),
      .peer_last_addr_i(last_addr[PEER]),
      .peer_last_enc_i (last_enc[PEER]),
      .s2_vld_o        (s2_vld[g]),
      .s2_addr_o       (s2_addr[g]),
      .s2_data_o       (s2_data[g]),
      .enc_o           (enc[g]),
      .last_vld_o      (last_vld[g]),
      .last_addr_o     (last_addr[g]),
      .last_enc_o      (last_enc[g])
    );

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
      logic [AW-1:0] bank_raddr;
      if (c < NRD) begin : g_rd
        assign bank_raddr = rd_addr[c];
      end else begin : g_cross
        assign bank_raddr = wr_addr[PEER];
      end

      xmp_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk_i  (clk_i),
        .we_i   (s2_vld[g]),
        .waddr_i(s2_addr[g]),
        .wdata_i(enc[g]),
        .raddr_i(bank_raddr),
        .rdata_o(bank_q[g][c])
      );
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rport
    xmp_rport #(.AW(AW), .WIDTH(WIDTH), .RW_RULE(RW_RULE)) u_rport (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .raddr_i  (rd_addr[r]),
      .bank0_i  (bank_q[0][r]),
      .bank1_i  (bank_q[1][r]),
      .wr_en_i  (wr_en),
      .wr_addr_i(wr_addr),
      .wr_data_i(wr_data),
      .s2_vld_i (s2_vld),
      .s2_addr_i(s2_addr),
      .s2_data_i(s2_data),
      .rdata_o  (rd_data[r])
    );
  end

  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];

  assert_port1_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0_en_i && wr1_en_i && wr0_addr_i == wr1_addr_i) |=> (!s2_vld[0] && s2_vld[1] && s2_data[1] == $past(wr1_data_i)));

  assert_idle_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr0_en_i && !wr1_en_i) |=> (s2_vld == '0));

  assert_s2_onehot_collision_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_vld == 2'b11) |-> (s2_addr[0] != s2_addr[1]));
endmodule

// File: tb/xmp_regfile_bench.sv
module xmp_regfile_bench;
  import xmp_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int WIDTH = 32;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic             wr0_en = 0, wr1_en = 0;
  logic [AW-1:0]    wr0_addr = '0, wr1_addr = '0, rd0_addr = '0, rd1_addr = '0;
  logic [WIDTH-1:0] wr0_data = '0, wr1_data = '0;
  logic [WIDTH-1:0] o_rd0, o_rd1, n_rd0, n_rd1;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmp_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RW_RULE(RULE_OLD)) u_xmp_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr0_en_i(wr0_en), .wr0_addr_i(wr0_addr), .wr0_data_i(wr0_data),
    .wr1_en_i(wr1_en), .wr1_addr_i(wr1_addr), .wr1_data_i(wr1_data),
    .rd0_addr_i(rd0_addr), .rd0_data_o(o_rd0),
    .rd1_addr_i(rd1_addr), .rd1_data_o(o_rd1));

  xmp_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RW_RULE(RULE_NEW)) u_xmp_regfile_new (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr0_en_i(wr0_en), .wr0_addr_i(wr0_addr), .wr0_data_i(wr0_data),
    .wr1_en_i(wr1_en), .wr1_addr_i(wr1_addr), .wr1_data_i(wr1_data),
    .rd0_addr_i(rd0_addr), .rd0_data_o(n_rd0),
    .rd1_addr_i(rd1_addr), .rd1_data_o(n_rd1));

  logic [WIDTH-1:0] mdl [DEPTH];
  int n_vec = 0, n_err = 0;
  bit done = 0;
  bit pend = 0;
  string pend_tag;
  logic [WIDTH-1:0] eo0, eo1, en0, en1;

  task automatic cmp(string tag, string what, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] peek(logic [AW-1:0] a);
    return mdl[a];
  endfunction

  task automatic step(string tag, bit e0, logic [AW-1:0] a0, logic [WIDTH-1:0] d0,
                      bit e1, logic [AW-1:0] a1, logic [WIDTH-1:0] d1,
                      logic [AW-1:0] r0, logic [AW-1:0] r1);
    @(negedge clk);
    if (pend) begin
      cmp(pend_tag, "old rule rd0", o_rd0, eo0);
      cmp(pend_tag, "old rule rd1", o_rd1, eo1);
      cmp(pend_tag, "new rule rd0", n_rd0, en0);
      cmp(pend_tag, "new rule rd1", n_rd1, en1);
    end
    wr0_en = e0; wr0_addr = a0; wr0_data = d0;
    wr1_en = e1; wr1_addr = a1; wr1_data = d1;
    rd0_addr = r0; rd1_addr = r1;
    eo0 = peek(r0); eo1 = peek(r1);
    if (e0) mdl[a0] = d0;
    if (e1) mdl[a1] = d1;  // port 1 applied last: it wins
    en0 = peek(r0); en1 = peek(r1);
    pend = 1;
    pend_tag = tag;
  endtask

  task automatic idle_read(string tag, logic [AW-1:0] r0, logic [AW-1:0] r1);
    step(tag, 0, '0, '0, 0, '0, '0, r0, r1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: power-up contents
    idle_read("R1", 5'd0, 5'd31);
    idle_read("R1", 5'd17, 5'd9);

    // R2 R3: write then read on the following cycles
    step("R2", 1, 5'd3, 32'hA5A5_0003, 0, '0, '0, 5'd0, 5'd0);
    idle_read("R3", 5'd3, 5'd3);
    idle_read("R3", 5'd3, 5'd0);

    // R5 R4: disjoint concurrent writes, independent reads
    step("R5", 1, 5'd4, 32'h1111_0004, 1, 5'd9, 32'h2222_0009, 5'd1, 5'd2);
    idle_read("R4", 5'd4, 5'd9);
    idle_read("R4", 5'd9, 5'd4);

    // R6: collision, port 1 wins; reads immediately and later
    step("R6", 1, 5'd7, 32'hDEAD_0007, 1, 5'd7, 32'hBEEF_0007, 5'd7, 5'd7);
    idle_read("R6", 5'd7, 5'd7);
    idle_read("R6", 5'd7, 5'd6);
    step("R6", 1, 5'd7, 32'h0BAD_0007, 0, '0, '0, 5'd7, 5'd7);
    idle_read("R6", 5'd7, 5'd7);

    // R7: back-to-back alternating and same-port writes to one address
    step("R7", 1, 5'd10, 32'h0000_AAAA, 0, '0, '0, 5'd10, 5'd11);
    step("R7", 0, '0, '0, 1, 5'd10, 32'h0000_BBBB, 5'd10, 5'd10);
    step("R7", 1, 5'd10, 32'h0000_CCCC, 0, '0, '0, 5'd10, 5'd10);
    step("R7", 1, 5'd10, 32'h0000_DDDD, 1, 5'd11, 32'h0000_EEEE, 5'd10, 5'd11);
    step("R7", 0, '0, '0, 1, 5'd10, 32'h0000_FFFF, 5'd10, 5'd11);
    step("R7", 0, '0, '0, 1, 5'd10, 32'h0000_1234, 5'd10, 5'd10);
    idle_read("R7", 5'd10, 5'd11);
    idle_read("R7", 5'd10, 5'd10);

    // R8 R9: read of an address written in the same cycle
    step("R8", 1, 5'd12, 32'hC0DE_0012, 0, '0, '0, 5'd12, 5'd12);
    step("R9", 1, 5'd13, 32'h5555_0013, 1, 5'd13, 32'h6666_0013, 5'd13, 5'd12);
    idle_read("R8", 5'd13, 5'd12);

    // R10: enables low with live address and data
    step("R10", 0, 5'd3, 32'hFFFF_FFFF, 0, 5'd4, 32'hFFFF_FFFF, 5'd3, 5'd4);
    idle_read("R10", 5'd3, 5'd4);

    // random traffic in a narrow window to raise hazard rate
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] a0, a1, r0, r1;
      a0 = AW'($urandom_range(0, 7));
      a1 = AW'($urandom_range(0, 7));
      r0 = AW'($urandom_range(0, 7));
      r1 = AW'($urandom_range(0, 7));
      step("R3", ($urandom_range(0, 3) != 0), a0, $urandom,
                 ($urandom_range(0, 3) != 0), a1, $urandom, r0, r1);
    end
    idle_read("R3", 5'd0, 5'd1);
    idle_read("R3", 5'd2, 5'd3);
    finish_run();
  end
endmodule